// File: doc/BRIEF.md
# Extended-Period Sampling Event Counter

This block counts events and raises a sample interrupt once a programmable number of them has been seen. The period may be far longer than the hardware counter can span. The counter's most significant bit serves as its overflow request, so one pass of the counter covers at most half its range. A longer period is therefore assembled from several passes. The block keeps a signed remaining-period value and, at each intermediate overflow, subtracts the events just counted and reloads the counter in the same cycle. Only the final overflow reaches the consumer.

Software programs the period through a one-cycle write strobe. It then waits for the sample interrupt and acknowledges it, after which the same period starts again. A period of zero turns the interrupt off while the counter keeps running.

Top module: `xperiod_sampler`

## Requirements
- R1: After reset, sampleIrq is 0, counterOut is 0 and the programmed period is zero, so sampling is disabled.
- R2: A cycle with periodWr high stores periodIn as both the programmed and the remaining period, and clears sampleIrq. It loads the counter with 2^(CNT_W-1) - periodIn when 0 < periodIn < 2^(CNT_W-1), and with 0 otherwise. An event in that same cycle is added to the loaded value.
- R3: Outside load cycles, counterOut increases by exactly one in every cycle where eventIn is high and holds otherwise. Bit CNT_W-1 of the counter is the overflow request.
- R4: When the overflow bit is set and the remaining period exceeds 2^(CNT_W-1), the remaining period drops by 2^(CNT_W-1) and the counter is reloaded in the next cycle by the rule of R2. No interrupt is raised.
- R5: For any non-zero period P, sampleIrq rises on the clock edge after the edge that counts the P-th event since the last period write or acknowledge, and never earlier.
- R6: An event that arrives in a reload cycle is counted toward the period and is not lost.
- R7: sampleIrq stays high until it is acknowledged or a period is written. An irqAck while no interrupt is pending has no effect on counterOut or sampleIrq.
- R8: Acknowledging a pending interrupt clears it and restarts the count from the programmed period. The counter is loaded by the rule of R2, and an event in the acknowledge cycle is counted.
- R9: With a period of zero, sampleIrq never rises and the counter counts every event from 0, wrapping modulo 2^CNT_W.
- R10: A period write in the same cycle as an acknowledge takes priority: the counter is loaded from the new period, not the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventIn | input | 1 | One event counted per cycle when high |
| periodWr | input | 1 | Load strobe for periodIn |
| periodIn | input | PERIOD_W | New sampling period, zero disables interrupts |
| irqAck | input | 1 | Acknowledge of the sample interrupt |
| sampleIrq | output | 1 | Sample interrupt, held until acknowledged |
| counterOut | output | CNT_W | Live hardware counter value |

## Verification
The bench runs with an 8-bit counter so that periods spanning one, two and several passes all fit in a short run. It aims at the reload cycle and at periods just above and exactly at half the counter range. A design that drops the reload-cycle event or miscounts elapsed events would fire one or more cycles late. A design that forwards an intermediate overflow would fire early. The bench also checks an acknowledge with nothing pending, a write that coincides with an acknowledge, and a zero period. In those cases a faulty design would restart the count, reload from the stale period, or fire on counter wrap.

// File: rtl/sampctr_pkg.sv
package sampctr_pkg;
  // Control-to-datapath strobes, at most one high per cycle
  typedef struct packed {
    logic writeP;   // load a new programmed period
    logic restart;  // acknowledged interrupt: start the period again
    logic reload;   // intermediate overflow: step down and reload
    logic finish;   // final overflow: period elapsed
  } sampStrobe_t;
endpackage

// File: rtl/samp_datapath.sv
module samp_datapath
  import sampctr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PERIOD_W = 63
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                eventIn,
  input  logic [PERIOD_W-1:0] periodIn,
  input  sampStrobe_t         strb,
  output logic                topBit,
  output logic                remLeHalf,
  output logic                enabled,
  output logic [CNT_W-1:0]    cntOut
);
  localparam logic [CNT_W-1:0]           HALF   = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [PERIOD_W:0]   HALF_S = {{(PERIOD_W+1-CNT_W){1'b0}}, HALF};

  logic [PERIOD_W-1:0]      periodQ;
  logic signed [PERIOD_W:0] remQ, remNext;
  logic [CNT_W-1:0]         cntQ, cntBase;

  function automatic logic [CNT_W-1:0] loadFor(input logic signed [PERIOD_W:0] r);
    if (r <= 0 || r >= HALF_S) return '0;
    else return HALF - r[CNT_W-1:0];
  endfunction

  always_comb begin
    remNext = remQ;
    cntBase = cntQ;
    if (strb.writeP) begin
      remNext = signed'({1'b0, periodIn});
      cntBase = loadFor(remNext);
    end else if (strb.restart) begin
      remNext = signed'({1'b0, periodQ});
      cntBase = loadFor(remNext);
    end else if (strb.reload) begin
      remNext = remQ - HALF_S;
      cntBase = loadFor(remNext);
    end else if (strb.finish) begin
      remNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
      remQ    <= '0;
      cntQ    <= '0;
    end else begin
      if (strb.writeP) periodQ <= periodIn;
      remQ <= remNext;
      cntQ <= cntBase + {{(CNT_W-1){1'b0}}, eventIn};
    end
  end

  assign topBit    = cntQ[CNT_W-1];
  assign remLeHalf = remQ <= HALF_S;
  assign enabled   = periodQ != '0;
  assign cntOut    = cntQ;

  // R4: remaining period is never driven negative
  assert_rem_nonneg_R4: assert property (@(posedge clk) disable iff (!rstN)
    remQ >= 0);
  // R4: an intermediate pass removes exactly half the counter range
  assert_reload_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> remQ == $past(remQ) - HALF_S);
  // R3: without strobes the counter follows the event input
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn && strb == '0) |=> cntQ == $past(cntQ) + 1'b1);
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!eventIn && strb == '0) |=> $stable(cntQ));
endmodule

// File: rtl/samp_ctrl.sv
module samp_ctrl
  import sampctr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        periodWr,
  input  logic        irqAck,
  input  logic        topBit,
  input  logic        remLeHalf,
  input  logic        enabled,
  output sampStrobe_t strb,
  output logic        irqOut
);
  logic irqQ;
  logic passDone;

  assign passDone     = topBit && enabled && !irqQ && !periodWr;
  assign strb.writeP  = periodWr;
  assign strb.restart = !periodWr && irqAck && irqQ;
  assign strb.reload  = passDone && !remLeHalf;
  assign strb.finish  = passDone && remLeHalf;

  always_ff @(posedge clk) begin
    if (!rstN)                          irqQ <= 1'b0;
    else if (strb.writeP || strb.restart) irqQ <= 1'b0;
    else if (strb.finish)               irqQ <= 1'b1;
  end

  assign irqOut = irqQ;

  // R7: a pending interrupt is held until acknowledged or overwritten
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !irqAck && !periodWr) |=> irqQ);
  // R5: the interrupt only rises after an overflow seen with sampling enabled
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !$past(irqQ)) |-> $past(topBit && enabled));
  // R9: with sampling disabled no interrupt is raised
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !irqQ && !periodWr) |=> !irqQ);
endmodule

// File: rtl/xperiod_sampler.sv
module xperiod_sampler
  import sampctr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PERIOD_W = 63
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                eventIn,
  input  logic                periodWr,
  input  logic [PERIOD_W-1:0] periodIn,
  input  logic                irqAck,
  output logic                sampleIrq,
  output logic [CNT_W-1:0]    counterOut
);
  sampStrobe_t strb;
  logic topBit, remLeHalf, enabled;

  samp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .periodWr(periodWr), .irqAck(irqAck),
    .topBit(topBit), .remLeHalf(remLeHalf), .enabled(enabled),
    .strb(strb), .irqOut(sampleIrq)
  );

  samp_datapath #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) u_dp (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .periodIn(periodIn),
    .strb(strb), .topBit(topBit), .remLeHalf(remLeHalf),
    .enabled(enabled), .cntOut(counterOut)
  );
endmodule

// File: tb/sim_xperiod_sampler.sv
module sim_xperiod_sampler;
  localparam int CW = 8;
  localparam int PW = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eventIn = 1'b0, periodWr = 1'b0, irqAck = 1'b0;
  logic [PW-1:0] periodIn = '0;
  logic sampleIrq;
  logic [CW-1:0] counterOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural reference: events since (re)start versus period
  longint evCnt = 0;
  longint mP = 0;
  bit irqM = 1'b0;

  always #2 clk = ~clk;

  xperiod_sampler #(.CNT_W(CW), .PERIOD_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .periodWr(periodWr),
    .periodIn(periodIn), .irqAck(irqAck), .sampleIrq(sampleIrq),
    .counterOut(counterOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mP = 0; evCnt = 0; irqM = 1'b0;
    end else if (periodWr) begin
      mP = longint'(periodIn); evCnt = eventIn ? 1 : 0; irqM = 1'b0;
    end else if (irqAck && irqM) begin
      irqM = 1'b0; evCnt = eventIn ? 1 : 0;
    end else begin
      if (mP != 0 && !irqM && evCnt >= mP) irqM = 1'b1;
      if (!irqM && eventIn) evCnt = evCnt + 1;
    end
  end

  // R5, R6, R7, R9: interrupt compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (sampleIrq !== irqM) begin
        errors++;
        $display("FAIL R5 sampleIrq per-cycle at %0t: actual %0b expected %0b (period %0d)",
                 $time, sampleIrq, irqM, mP);
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit ev, bit wr, int p, bit ack);
    eventIn = ev; periodWr = wr; periodIn = PW'(p); irqAck = ack;
    @(negedge clk);
    eventIn = 1'b0; periodWr = 1'b0; irqAck = 1'b0;
  endtask

  task automatic events(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 1'b0);
  endtask

  task automatic randPhase(int p, int cyc, int prob);
    step(1'b0, 1'b1, p, 1'b0);
    for (int i = 0; i < cyc; i++)
      step(($urandom % 100) < prob, 1'b0, 0, sampleIrq && ($urandom % 4 == 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", sampleIrq, 0);
    chk("R1 counter after reset", counterOut, 0);

    // R2 short period load, R3 counting, R5 timing
    step(1'b0, 1'b1, 3, 1'b0);
    chk("R2 load for period 3", counterOut, 125);
    events(3);
    chk("R3 counter after 3 events", counterOut, 128);
    step(1'b0, 1'b0, 0, 1'b0);
    chk("R5 irq after period 3", sampleIrq, 1);
    // R8 restart from programmed period
    step(1'b0, 1'b0, 0, 1'b1);
    chk("R8 irq cleared by ack", sampleIrq, 0);
    chk("R8 counter reloaded", counterOut, 125);

    // R7 stray ack ignored
    step(1'b0, 1'b1, 50, 1'b0);
    events(5);
    step(1'b0, 1'b0, 0, 1'b1);
    chk("R7 stray ack keeps counter", counterOut, 83);
    chk("R7 stray ack keeps irq", sampleIrq, 0);

    // R4 multi-pass, R6 event in reload cycle
    step(1'b0, 1'b1, 300, 1'b0);
    chk("R2 load for long period", counterOut, 0);
    events(128);
    chk("R4 overflow bit set", counterOut, 128);
    step(1'b0, 1'b0, 0, 1'b0);
    chk("R4 reload on intermediate pass", counterOut, 0);
    chk("R4 no irq on intermediate pass", sampleIrq, 0);
    events(128);
    step(1'b1, 1'b0, 0, 1'b0);
    chk("R6 event in reload cycle counted", counterOut, 85);
    events(43);
    step(1'b0, 1'b0, 0, 1'b0);
    chk("R5 irq after period 300", sampleIrq, 1);

    // R10 write beats ack
    step(1'b0, 1'b1, 3, 1'b0);
    events(3);
    step(1'b0, 1'b0, 0, 1'b0);
    chk("R10 irq pending before", sampleIrq, 1);
    step(1'b0, 1'b1, 5, 1'b1);
    chk("R10 load from new period", counterOut, 123);
    chk("R10 irq cleared", sampleIrq, 0);

    // R9 disabled period
    step(1'b0, 1'b1, 0, 1'b0);
    chk("R9 load for zero period", counterOut, 0);
    events(200);
    chk("R9 free count", counterOut, 200);
    events(100);
    chk("R9 wrap", counterOut, 44);
    chk("R9 no irq", sampleIrq, 0);

    // random phases across pass boundaries (R4, R5, R6, R8)
    randPhase(1, 200, 70);
    randPhase(127, 1500, 80);
    randPhase(128, 1500, 90);
    randPhase(129, 1500, 100);
    randPhase(256, 2500, 60);
    randPhase(257, 2500, 95);
    randPhase(1000, 6000, 85);
    randPhase(32767, 40000, 100);
    randPhase(0, 600, 90);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule